// File: doc/BRIEF.md
# Prioritized Core Interrupt Controller

This block sits in front of a processor core and chooses which of sixteen priority levels to present to it. Level 0 carries the reset request and level 1 carries the non-maskable interrupt. Levels 2 and 3 are reserved and are never active. Twelve external request lines drive levels 4 through 15. When a request line rises, the pending flag for that level is set. The flag stays set until the core acknowledges that level or software clears it.

The core sees a valid flag and a 4-bit level number. The number is the lowest-numbered level that is both pending and eligible. Maskable levels need their own enable bit and the global enable to be eligible. Reset and NMI are always eligible. A small register port sets the per-level enable mask and the global enable. The same port reads the pending flags and can set or clear them.

Top module: `core_irq_ctrl`

## Requirements
- R1: After reset, all pending flags are zero, the enable mask is zero, the global enable is off, the valid output is low and the level output is zero.
- R2: A rising edge on a request line sets that level's pending flag at the next clock edge. Request bit i of the external bus drives level i+4. A line held high does not set the flag again once it has been cleared.
- R3: Levels 2 and 3 never become pending, even when software writes them. They read as zero and are never presented.
- R4: A level from 4 to 15 is presented only when its enable bit and the global enable are both set. A masked level stays pending and stays visible in the pending register.
- R5: Reset (level 0) and NMI (level 1) are presented whatever the state of the mask and the global enable.
- R6: The lowest-numbered eligible pending level wins. Reset beats NMI, and NMI beats every maskable level.
- R7: An acknowledge clears only the pending flag of the level it names. If a new rising edge on that same level arrives in the same cycle, the flag stays set.
- R8: Software sets pending flags with write-1-to-set at address 2 and clears them with write-1-to-clear at address 3. Bit n of the data stands for level n. A rising edge on a level overrides a software clear of it in the same cycle.
- R9: When nothing eligible is pending, the valid output is low and the level output is zero.
- R10: Register map:
  - Address 0 holds the enable mask, with bit n for level n. Bits 15:4 are writable and bits 3:0 read as zero.
  - Address 1, bit 0, is the global enable.
  - Addresses 2 and 3 both read the pending flags.
  - Read data is combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_req | input | 1 | Reset request line (level 0) |
| nmi_req | input | 1 | Non-maskable interrupt line (level 1) |
| ext_req | input | 12 | External request lines; bit i drives level i+4 |
| ack_valid | input | 1 | Core acknowledges a level this cycle |
| ack_level | input | 4 | Level being acknowledged |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq_valid | output | 1 | An eligible level is pending |
| irq_level | output | 4 | Winning level number, zero when idle |

## Verification
The bench holds a request line high across an acknowledge. A design that sets its flags on level rather than edge would raise the interrupt again at once. It fires an edge on a level in the same cycle as an acknowledge or a software clear of that level. A design where the clear wins would lose that request. It writes ones to the reserved levels and the low mask bits; a design that stores them could present level 2 or 3. It also raises several levels together, and raises reset and NMI with the mask off, so a design with a reversed priority encoder or with masking applied to reset or NMI would present the wrong level.

// File: rtl/cic_pkg.sv
package cic_pkg;

    localparam int unsigned LVL_RESET = 0;
    localparam int unsigned LVL_NMI   = 1;
    localparam int unsigned FIRST_EXT = 4;

    typedef enum logic [1:0] {
        REG_MASK = 2'd0,
        REG_CTRL = 2'd1,
        REG_PSET = 2'd2,
        REG_PCLR = 2'd3
    } reg_sel_e;

    // Levels that can hold a pending flag: all except the reserved pair.
    function automatic logic [31:0] impl_levels(input int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = 0; i < n; i++) begin
            if (i != 2 && i != 3) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Levels fed by external request lines.
    function automatic logic [31:0] ext_levels(input int unsigned n);
        logic [31:0] m;
        m = '0;
        for (int unsigned i = FIRST_EXT; i < n; i++) m[i] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/cic_edge.sv
module cic_edge #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = req;
        rise   = req & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cic_pend.sv
module cic_pend
    import cic_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise,
    input  logic [N-1:0] sw_set,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] pend_q
);
    localparam logic [N-1:0] IMPL = N'(impl_levels(N));

    logic [N-1:0] pend_d;

    always_comb begin
        // Sets dominate clears so a same-cycle edge is never lost.
        pend_d = ((pend_q & ~(ack_clr | sw_clr)) | rise | sw_set) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        if (IMPL[i]) begin : g_impl
            AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                rise[i] |=> pend_q[i]); // R2
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_clr[i] && !rise[i] && !sw_set[i]) |=> !pend_q[i]); // R7
            AST_ACK_KEEPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_clr[i] && rise[i]) |=> pend_q[i]); // R7
        end
    end
endmodule

// File: rtl/cic_prio.sv
module cic_prio #(
    parameter int unsigned N  = 16,
    parameter int unsigned LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    output logic          valid,
    output logic [LW-1:0] level
);
    always_comb begin
        valid = 1'b0;
        level = '0;
        // Walk downward so the lowest set index is the last assignment.
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                valid = 1'b1;
                level = LW'(i);
            end
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> level == '0); // R9
    AST_RSVD_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (level != LW'(2) && level != LW'(3))); // R3
    AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> elig[level]); // R6
endmodule

// File: rtl/core_irq_ctrl.sv
module core_irq_ctrl
    import cic_pkg::*;
#(
    parameter int unsigned N_LVL = 16,
    parameter int unsigned LW    = $clog2(N_LVL),
    parameter int unsigned N_EXT = N_LVL - FIRST_EXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_req,
    input  logic             nmi_req,
    input  logic [N_EXT-1:0] ext_req,
    input  logic             ack_valid,
    input  logic [LW-1:0]    ack_level,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [N_LVL-1:0] reg_wdata,
    output logic [N_LVL-1:0] reg_rdata,
    output logic             irq_valid,
    output logic [LW-1:0]    irq_level
);
    localparam logic [N_LVL-1:0] EXT_M  = N_LVL'(ext_levels(N_LVL));
    localparam logic [N_LVL-1:0] FORCED = N_LVL'((1 << LVL_RESET) | (1 << LVL_NMI));

    typedef struct packed {
        logic [N_LVL-1:0] mask;
        logic             gie;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic [N_LVL-1:0] req_all, rise, sw_set, sw_clr, ack_clr, pend_q, elig;
    reg_sel_e         sel;

    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        req_all = '0;
        req_all[LVL_RESET] = rst_req;
        req_all[LVL_NMI]   = nmi_req;
        req_all[N_LVL-1:FIRST_EXT] = ext_req;

        cfg_d  = cfg_q;
        sw_set = '0;
        sw_clr = '0;
        if (reg_wr) begin
            unique case (sel)
                REG_MASK: cfg_d.mask = reg_wdata & EXT_M;
                REG_CTRL: cfg_d.gie  = reg_wdata[0];
                REG_PSET: sw_set     = reg_wdata;
                REG_PCLR: sw_clr     = reg_wdata;
            endcase
        end

        ack_clr = ack_valid ? (N_LVL'(1) << ack_level) : '0;

        elig = pend_q & (FORCED | (cfg_q.mask & {N_LVL{cfg_q.gie}}));

        unique case (sel)
            REG_MASK: reg_rdata = cfg_q.mask;
            REG_CTRL: reg_rdata = {{(N_LVL-1){1'b0}}, cfg_q.gie};
            default:  reg_rdata = pend_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    cic_edge #(.W(N_LVL)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (req_all),
        .rise (rise)
    );

    cic_pend #(.N(N_LVL)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise   (rise),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .ack_clr(ack_clr),
        .pend_q (pend_q)
    );

    cic_prio #(.N(N_LVL), .LW(LW)) u_prio (
        .clk  (clk),
        .rst_n(rst_n),
        .elig (elig),
        .valid(irq_valid),
        .level(irq_level)
    );

    AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q[LVL_RESET] |-> (irq_valid && irq_level == '0)); // R6
    AST_NMI_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[LVL_NMI] && !pend_q[LVL_RESET]) |-> (irq_valid && irq_level == LW'(LVL_NMI))); // R5
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_level >= LW'(FIRST_EXT)) |-> (cfg_q.gie && cfg_q.mask[irq_level])); // R4
    AST_LOW_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.mask[FIRST_EXT-1:0] == '0); // R10
endmodule

// File: tb/core_irq_ctrl_test.sv
`timescale 1ns/1ps
module core_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rst_req, nmi_req, ack_valid, reg_wr;
    logic [11:0] ext_req;
    logic [3:0]  ack_level;
    logic [1:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        irq_valid;
    logic [3:0]  irq_level;

    always #2 clk = ~clk;

    core_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
        .ext_req(ext_req), .ack_valid(ack_valid), .ack_level(ack_level),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_valid(irq_valid), .irq_level(irq_level)
    );

    typedef struct {
        int          due;
        logic        v;
        logic [3:0]  l;
        logic [15:0] rd;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc++;

    // Monitor: one cycle after the driving negedge's following posedge.
    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (irq_valid !== e.v || irq_level !== e.l || reg_rdata !== e.rd) begin
                n_fail++;
                $display("FAIL %s: got v=%0b lvl=%0d rd=%h, exp v=%0b lvl=%0d rd=%h",
                         e.tag, irq_valid, irq_level, reg_rdata, e.v, e.l, e.rd);
            end
        end
    end

    task automatic drv(input logic [11:0] e, input logic r, input logic n,
                       input logic av, input logic [3:0] al,
                       input logic w, input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        ext_req = e; rst_req = r; nmi_req = n;
        ack_valid = av; ack_level = al;
        reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic expect_nx(input logic v, input logic [3:0] l,
                             input logic [15:0] rd, input string tag);
        exp_t e;
        e.due = cyc + 1; e.v = v; e.l = l; e.rd = rd; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang, exp completion");
        summary();
    end

    initial begin
        rst_n = 1'b0;
        ext_req = '0; rst_req = 0; nmi_req = 0; ack_valid = 0; ack_level = '0;
        reg_wr = 0; reg_addr = 2'd2; reg_wdata = '0;
        repeat (3) @(negedge clk);
        n_chk++;
        if (irq_valid !== 1'b0 || irq_level !== 4'd0) begin
            n_fail++;
            $display("FAIL R1 in reset: got v=%0b lvl=%0d, exp v=0 lvl=0", irq_valid, irq_level);
        end
        rst_n = 1'b1;

        drv(12'h000, 0, 0, 0, 4'd0, 0, 2'd2, 16'h0);    expect_nx(0, 0, 16'h0000, "R1 pending clear");
        drv(12'h000, 0, 0, 0, 4'd0, 0, 2'd0, 16'h0);    expect_nx(0, 0, 16'h0000, "R1 mask zero R9");
        drv(12'h001, 0, 0, 0, 4'd0, 0, 2'd2, 16'h0);    expect_nx(0, 0, 16'h0010, "R4 masked but pending R2");
        drv(12'h001, 0, 0, 0, 4'd0, 1, 2'd0, 16'hFFFF); expect_nx(0, 0, 16'hFFF0, "R10 mask readback");
        drv(12'h001, 0, 0, 0, 4'd0, 1, 2'd1, 16'h0001); expect_nx(1, 4, 16'h0001, "R4 global enable");
        drv(12'h001, 0, 0, 1, 4'd4, 0, 2'd2, 16'h0);    expect_nx(0, 0, 16'h0000, "R7 ack clears");
        drv(12'h000, 0, 0, 0, 4'd0, 0, 2'd2, 16'h0);    expect_nx(0, 0, 16'h0000, "R2 held line no re-set");
        drv(12'h024, 0, 0, 0, 4'd0, 0, 2'd2, 16'h0);    expect_nx(1, 6, 16'h0240, "R6 lowest wins");
        drv(12'h000, 0, 0, 1, 4'd6, 0, 2'd2, 16'h0);    expect_nx(1, 9, 16'h0200, "R7 only named level");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd0, 16'h0000); expect_nx(0, 0, 16'h0000, "R4 mask bit off");
        drv(12'h000, 0, 1, 0, 4'd0, 0, 2'd2, 16'h0);    expect_nx(1, 1, 16'h0202, "R5 nmi ignores mask");
        drv(12'h000, 1, 1, 0, 4'd0, 0, 2'd2, 16'h0);    expect_nx(1, 0, 16'h0203, "R6 reset beats nmi R5");
        drv(12'h000, 1, 1, 1, 4'd0, 0, 2'd2, 16'h0);    expect_nx(1, 1, 16'h0202, "R7 ack reset level");
        drv(12'h000, 1, 1, 1, 4'd1, 0, 2'd2, 16'h0);    expect_nx(0, 0, 16'h0200, "R9 idle with masked pending");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd2, 16'h000C); expect_nx(0, 0, 16'h0200, "R3 reserved not settable");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd0, 16'hFFFF); expect_nx(1, 9, 16'hFFF0, "R4 re-enabled");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd2, 16'h8000); expect_nx(1, 9, 16'h8200, "R8 software set");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd3, 16'h0200); expect_nx(1, 15, 16'h8000, "R8 software clear");
        drv(12'h800, 0, 0, 1, 4'd15, 0, 2'd2, 16'h0);   expect_nx(1, 15, 16'h8000, "R7 ack with same edge");
        drv(12'h802, 0, 0, 0, 4'd0, 1, 2'd3, 16'h8000); expect_nx(1, 5, 16'h0020, "R8 clear and R6 new");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd1, 16'h0000); expect_nx(0, 0, 16'h0000, "R4 global off");
        drv(12'h000, 0, 0, 0, 4'd0, 1, 2'd3, 16'h0020); expect_nx(0, 0, 16'h0000, "R8 clear to idle R9");
        drv(12'h008, 0, 0, 0, 4'd0, 1, 2'd3, 16'h0080); expect_nx(0, 0, 16'h0080, "R8 edge beats clear");
        drv(12'h000, 0, 0, 0, 4'd0, 0, 2'd2, 16'h0);

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d unchecked, exp 0", q.size());
        end
        summary();
    end
endmodule